// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged FIFO

This block turns an asynchronous serial line into stored bytes. A one-cycle enable pulse at sixteen times the baud rate drives all of its timing. A falling edge on the idle-high line starts a frame. The receiver checks that the line is still low half a bit later. It then samples each data bit, an optional parity bit and the first stop bit at the centre of its bit cell. The data length (5 to 8 bits) and the parity mode are set by static configuration inputs, the same format fields a matching transmitter uses.

Each finished frame is written into a 16-entry FIFO. The entry holds the data byte and three flags of its own: parity error, framing error and break. The block shows the entry at the FIFO head on its read port, and a one-cycle `pop` strobe removes it. Status outputs give data ready, a sticky overrun flag, the head entry's error flags, and an error-in-FIFO summary. A receiver-ready output rises when the fill reaches a selectable trigger level. A clear strobe empties the FIFO.

Top module: `osr_receiver`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `st_dr`, `st_oe`, `st_fifo_err` and `rx_ready` are all 0.
- R2: A low level is accepted as a start bit only if the line is still low on the 8th tick after the tick that first saw it low. A shorter low pulse stores no byte.
- R3: Data bits arrive LSB first. `cfg_len` gives the count: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Unused high bits of `rd_data` read 0.
- R4: With `cfg_par_en` = 1, the bit after the data is the parity bit. If `cfg_par_stick` = 0, it must make the count of ones even (`cfg_par_even` = 1) or odd (`cfg_par_even` = 0). If `cfg_par_stick` = 1, it must be 0 when `cfg_par_even` = 1 and 1 when `cfg_par_even` = 0. A mismatch sets the entry's parity flag. With `cfg_par_en` = 0 the flag is never set.
- R5: A stop bit sampled as 0 sets the entry's framing flag. The receiver then waits for the line to go high before it accepts another start bit.
- R6: A frame whose data, parity (if enabled) and stop bit are all 0 stores exactly one entry with data 0 and the break and framing flags set. Nothing more is received until the line returns high.
- R7: The FIFO keeps up to 16 entries in arrival order. `st_dr` is 1 exactly while it holds at least one entry. `pop` removes the head entry. `rd_data`, `st_pe`, `st_fe` and `st_bi` show the head entry.
- R8: A frame that completes while the FIFO is full is discarded and the stored entries are kept. `st_oe` goes to 1 and stays there until a `pop` or a `fifo_clr`.
- R9: `st_fifo_err` is 1 exactly while at least one stored entry has any of its three flags set.
- R10: `rx_ready` is 1 while the fill is at least the trigger level that `cfg_trig` selects: 00 = 1, 01 = 4, 10 = 8, 11 = 14.
- R11: A `fifo_clr` pulse empties the FIFO and clears `st_oe` on the next clock edge.
- R12: A `pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity / stick-to-0 select |
| cfg_par_stick | input | 1 | Fixed-value parity select |
| cfg_trig | input | 2 | Receiver-ready trigger level select |
| fifo_clr | input | 1 | Empty the FIFO |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Data byte of the head entry |
| st_dr | output | 1 | Data ready |
| st_oe | output | 1 | Overrun, sticky |
| st_pe | output | 1 | Parity flag of the head entry |
| st_fe | output | 1 | Framing flag of the head entry |
| st_bi | output | 1 | Break flag of the head entry |
| st_fifo_err | output | 1 | Some stored entry carries a flag |
| rx_ready | output | 1 | Fill at or above the trigger level |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that trusts the first low sample would store a phantom byte there. It sends frames in each data length and in every parity mode, with both correct and wrong parity bits. Wrong length masking or an inverted stick polarity would show up as bad data or false parity flags. A frame with a zero stop bit and a long all-zero break are each followed by a normal frame. A receiver that resumed hunting while the line was still low would record extra entries or lose the next byte. The bench also fills the FIFO past 16 and steps the trigger selection around each threshold. It drains a mix of flagged and clean entries one at a time. Each drain step shows whether overrun drops the new byte and keeps the old ones, and whether the error summary tracks the entries still stored.

// File: rtl/osr_pkg.sv
// Shared types for the oversampling receiver.
// Assumes: data bytes are at most 8 bits wide.
package osr_pkg;

    // One stored frame: data plus its own error flags
    typedef struct packed {
        logic [7:0] data;
        logic       pe;
        logic       fe;
        logic       bi;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_WAITHI,
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_t;

    function automatic logic has_flag(input rx_entry_t e);
        return e.pe | e.fe | e.bi;
    endfunction

endpackage

// File: rtl/osr_rx_sampler.sv
// Frame sampler: synchronises the line and validates the start bit.
// It samples every later bit at its centre and emits one entry per frame.
// Assumes: tick is a one-cycle enable at OVS times the baud rate, and
// SYNC_STAGES >= 2.
module osr_rx_sampler
    import osr_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       push,
    output rx_entry_t  push_entry
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    rx_state_t              state;
    logic [CW-1:0]          cnt;
    logic [2:0]             bidx;
    logic [2:0]             last_idx;
    logic [7:0]             shreg;
    logic                   par_q;
    logic                   exp_par;
    logic                   push_q;
    rx_entry_t              entry_q;

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end

    assign line     = sync_q[SYNC_STAGES-1];
    assign last_idx = {1'b0, cfg_len} + 3'd4;

    // Parity bit the configured mode demands for the collected data
    always_comb begin
        if (par_stick)     exp_par = ~par_even;
        else if (par_even) exp_par = ^shreg;
        else               exp_par = ~^shreg;
    end

    // Frame state machine, advanced on each oversampling tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_WAITHI;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            push_q  <= 1'b0;
            entry_q <= '0;
        end else begin
            push_q <= 1'b0;
            if (tick) begin
                case (state)
                    S_WAITHI: if (line) state <= S_IDLE;
                    S_IDLE: begin
                        if (!line) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            if (!line) begin
                                state <= S_DATA;
                                bidx  <= '0;
                                shreg <= '0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt         <= '0;
                            shreg[bidx] <= line;
                            if (bidx == last_idx) state <= par_en ? S_PAR : S_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt   <= '0;
                            par_q <= line;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt          <= '0;
                            push_q       <= 1'b1;
                            entry_q.data <= shreg;
                            entry_q.pe   <= par_en && (par_q != exp_par);
                            entry_q.fe   <= ~line;
                            entry_q.bi   <= ~line && (shreg == 8'h00) && (!par_en || !par_q);
                            state        <= line ? S_IDLE : S_WAITHI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_WAITHI;
                endcase
            end
        end
    end

    assign push       = push_q;
    assign push_entry = entry_q;

endmodule

// File: rtl/osr_rx_fifo.sv
// Receive FIFO of entries that carry their own flags.
// It drops a push that finds the FIFO full unless a pop frees a slot
// in the same cycle.
// Assumes: DEPTH is a power of two, and clr has priority over push and pop.
module osr_rx_fifo
    import osr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       push_ok,
    output logic                       pop_ok,
    output logic                       drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
    assign drop    = push && !push_ok;
    assign head    = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= push_entry;
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/osr_rx_status.sv
// Status logic: sticky overrun, the count of flagged entries and the
// trigger-level compare.
// Assumes: push_ok/pop_ok/drop come from the FIFO in the same cycle.
module osr_rx_status
    import osr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push_ok,
    input  logic                       pop_ok,
    input  logic                       drop,
    input  rx_entry_t                  push_entry,
    input  rx_entry_t                  head,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [1:0]                 trig_sel,
    output logic                       overrun,
    output logic                       fifo_err,
    output logic                       ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] err_cnt;
    logic [CW-1:0] level;

    // Sticky overrun: set by a dropped frame, cleared by a pop or a clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  overrun <= 1'b0;
        else if (drop)      overrun <= 1'b1;
        else if (pop_ok)    overrun <= 1'b0;
    end

    // Number of stored entries that carry any flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) err_cnt <= '0;
        else err_cnt <= err_cnt + CW'(push_ok && has_flag(push_entry))
                                - CW'(pop_ok && has_flag(head));
    end

    // Trigger level decode
    always_comb begin
        case (trig_sel)
            2'b00:   level = CW'(1);
            2'b01:   level = CW'(4);
            2'b10:   level = CW'(8);
            default: level = CW'(14);
        endcase
    end

    assign fifo_err = (err_cnt != '0);
    assign ready    = (count >= level);

endmodule

// File: rtl/osr_receiver.sv
// Top of the oversampling serial receiver: sampler, flag-carrying FIFO
// and status logic.
// Assumes: configuration inputs are static while a frame is in flight.
module osr_receiver
    import osr_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_stick,
    input  logic [1:0] cfg_trig,
    input  logic       fifo_clr,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       st_dr,
    output logic       st_oe,
    output logic       st_pe,
    output logic       st_fe,
    output logic       st_bi,
    output logic       st_fifo_err,
    output logic       rx_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push;
    rx_entry_t     push_entry;
    rx_entry_t     head;
    logic [CW-1:0] fifo_fill;
    logic          push_ok;
    logic          pop_ok;
    logic          drop;

    osr_rx_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .rxd        (rxd),
        .cfg_len    (cfg_len),
        .par_en     (cfg_par_en),
        .par_even   (cfg_par_even),
        .par_stick  (cfg_par_stick),
        .push       (push),
        .push_entry (push_entry)
    );

    osr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .count      (fifo_fill),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .drop       (drop)
    );

    osr_rx_status #(.DEPTH(DEPTH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .drop       (drop),
        .push_entry (push_entry),
        .head       (head),
        .count      (fifo_fill),
        .trig_sel   (cfg_trig),
        .overrun    (st_oe),
        .fifo_err   (st_fifo_err),
        .ready      (rx_ready)
    );

    // Head view, forced to zero while nothing is stored
    assign st_dr   = (fifo_fill != '0);
    assign rd_data = st_dr ? head.data : 8'h00;
    assign st_pe   = st_dr & head.pe;
    assign st_fe   = st_dr & head.fe;
    assign st_bi   = st_dr & head.bi;

endmodule

// File: rtl/osr_receiver_chk.sv
// Property checker for osr_receiver, attached with bind below.
// Assumes: fill is the FIFO occupancy of the bound instance.
module osr_receiver_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_clr,
    input logic                       pop,
    input logic                       st_dr,
    input logic                       st_oe,
    input logic                       st_pe,
    input logic                       st_fe,
    input logic                       st_bi,
    input logic                       st_fifo_err,
    input logic                       rx_ready,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!st_dr && !st_oe));

    a_r9_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        st_fifo_err |-> st_dr);

    a_r10_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> st_dr);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    a_r7_head_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pe || st_fe || st_bi) |-> st_dr);

    a_r8_oe_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_oe) |-> ($past(fill) == ($clog2(DEPTH+1))'(DEPTH)));

    a_r8_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_oe && !pop && !fifo_clr) |=> st_oe);

endmodule

bind osr_receiver osr_receiver_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_clr    (fifo_clr),
    .pop         (pop),
    .st_dr       (st_dr),
    .st_oe       (st_oe),
    .st_pe       (st_pe),
    .st_fe       (st_fe),
    .st_bi       (st_bi),
    .st_fifo_err (st_fifo_err),
    .rx_ready    (rx_ready),
    .fill        (fifo_fill)
);

// File: tb/sim_osr_receiver.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected entries, the monitor pops and compares.
module sim_osr_receiver;
    localparam int CPT = 4;             // clocks per oversampling tick
    localparam int BITCLK = 16 * CPT;   // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic [1:0] cfg_trig = 2'b00;
    logic       fifo_clr = 1'b0;
    logic       pop_mon = 1'b0;
    logic       pop_man = 1'b0;
    logic       pop;
    logic [7:0] rd_data;
    logic       st_dr, st_oe, st_pe, st_fe, st_bi, st_fifo_err, rx_ready;

    int tests = 0;
    int fails = 0;
    int budget = 0;
    int tcnt = 0;
    logic [10:0] expq [$];

    assign pop = pop_mon | pop_man;

    always #2.5 clk = ~clk;

    osr_receiver u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .cfg_trig(cfg_trig), .fifo_clr(fifo_clr),
        .pop(pop), .rd_data(rd_data), .st_dr(st_dr), .st_oe(st_oe), .st_pe(st_pe),
        .st_fe(st_fe), .st_bi(st_bi), .st_fifo_err(st_fifo_err), .rx_ready(rx_ready)
    );

    // Tick generator, one pulse every CPT clocks
    always @(negedge clk) begin
        tcnt   = (tcnt + 1) % CPT;
        tick16 = (tcnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int clocks);
        rxd = b;
        repeat (clocks) @(negedge clk);
    endtask

    // Driver: work out the expected entry, queue it if it will be stored, send the frame
    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit stored);
        int n;
        logic [7:0] m;
        logic p;
        logic [10:0] e;
        n = 5 + int'(cfg_len);
        m = d & 8'((1 << n) - 1);
        if (cfg_par_stick) p = ~cfg_par_even;
        else               p = cfg_par_even ? (^m) : ~(^m);
        p = p ^ bad_par;
        e = {m, cfg_par_en & bad_par, bad_stop,
             bad_stop & (m == 8'h00) & (!cfg_par_en | !p)};
        if (stored) expq.push_back(e);
        hold(1'b0, BITCLK);
        for (int i = 0; i < n; i++) hold(m[i], BITCLK);
        if (cfg_par_en) hold(p, BITCLK);
        hold(~bad_stop, BITCLK);
        hold(1'b1, BITCLK);
    endtask

    // Monitor: pop and compare while it has budget and data is ready
    always @(negedge clk) begin
        if (pop_mon) begin
            pop_mon = 1'b0;
        end else if (budget > 0 && st_dr) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7 unexpected entry", int'({rd_data, st_pe, st_fe, st_bi}), 0);
            end else begin
                logic [10:0] e;
                e = expq.pop_front();
                check({rd_data, st_pe, st_fe, st_bi} == e, "R3/R4/R5/R6/R7 entry",
                      int'({rd_data, st_pe, st_fe, st_bi}), int'(e));
            end
            pop_mon = 1'b1;
            budget--;
        end
    end

    task automatic drain(input int n);
        budget = n;
        while (budget != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(!st_dr && !st_oe && !st_fifo_err && !rx_ready, "R1 reset state",
              int'({st_dr, st_oe, st_fifo_err, rx_ready}), 0);
        repeat (BITCLK) @(negedge clk);

        // R3 eight-bit frames
        send(8'hA5, 0, 0, 1); send(8'h3C, 0, 0, 1); drain(2);
        // R3 shorter lengths mask the upper bits
        cfg_len = 2'b00; send(8'hFF, 0, 0, 1);
        cfg_len = 2'b01; send(8'hEA, 0, 0, 1);
        cfg_len = 2'b10; send(8'hD3, 0, 0, 1);
        drain(3);
        cfg_len = 2'b11;

        // R4 parity modes, correct and wrong
        cfg_par_en = 1; cfg_par_even = 1;
        send(8'h71, 0, 0, 1); send(8'h71, 1, 0, 1);
        cfg_par_even = 0;
        send(8'h24, 0, 0, 1); send(8'h24, 1, 0, 1);
        cfg_par_stick = 1; cfg_par_even = 1;
        send(8'h5A, 0, 0, 1); send(8'h5A, 1, 0, 1);
        cfg_par_even = 0;
        send(8'h0F, 0, 0, 1); send(8'h0F, 1, 0, 1);
        drain(8);
        cfg_par_en = 0; cfg_par_stick = 0;

        // R5 zero stop bit, then a normal frame
        send(8'h55, 0, 1, 1); send(8'h96, 0, 0, 1); drain(2);

        // R6 break: line low for two frame times, one entry, then a normal frame
        expq.push_back({8'h00, 1'b0, 1'b1, 1'b1});
        hold(1'b0, 22 * BITCLK); hold(1'b1, 2 * BITCLK);
        send(8'hC3, 0, 0, 1);
        drain(2);
        check(!st_dr, "R6 only one entry for the break", int'(st_dr), 0);

        // R2 short low pulse is ignored
        hold(1'b0, 3 * CPT); hold(1'b1, 3 * BITCLK);
        check(!st_dr, "R2 glitch stores nothing", int'(st_dr), 0);
        send(8'h81, 0, 0, 1); drain(1);

        // R10 trigger levels and R8 overrun
        cfg_trig = 2'b01;
        for (int i = 0; i < 3; i++) send(8'(i + 8'h10), 0, 0, 1);
        check(!rx_ready, "R10 below level 4", int'(rx_ready), 0);
        send(8'h13, 0, 0, 1);
        check(rx_ready, "R10 at level 4", int'(rx_ready), 1);
        cfg_trig = 2'b10; @(negedge clk);
        check(!rx_ready, "R10 below level 8", int'(rx_ready), 0);
        cfg_trig = 2'b00; @(negedge clk);
        check(rx_ready, "R10 above level 1", int'(rx_ready), 1);
        for (int i = 4; i < 13; i++) send(8'(i + 8'h10), 0, 0, 1);
        cfg_trig = 2'b11; @(negedge clk);
        check(!rx_ready, "R10 below level 14", int'(rx_ready), 0);
        send(8'h1D, 0, 0, 1);
        check(rx_ready, "R10 at level 14", int'(rx_ready), 1);
        send(8'h1E, 0, 0, 1); send(8'h1F, 0, 0, 1);
        check(st_dr && !st_oe, "R8 full without overrun", int'({st_dr, st_oe}), 2);
        send(8'hEE, 0, 0, 0);
        check(st_oe, "R8 overrun on full", int'(st_oe), 1);
        drain(16);
        check(!st_dr && !st_oe, "R8 overrun cleared by pop, contents kept",
              int'({st_dr, st_oe}), 0);
        cfg_trig = 2'b00;

        // R9 error summary follows the stored entries
        cfg_par_en = 1; cfg_par_even = 1;
        send(8'h01, 0, 0, 1); send(8'h02, 1, 0, 1); send(8'h03, 0, 0, 1);
        check(st_fifo_err, "R9 flagged entry stored", int'(st_fifo_err), 1);
        drain(1);
        check(st_fifo_err, "R9 flagged entry still stored", int'(st_fifo_err), 1);
        drain(1);
        check(!st_fifo_err && st_dr, "R9 flagged entry gone", int'({st_fifo_err, st_dr}), 1);
        drain(1);
        cfg_par_en = 0;

        // R11 clear empties the FIFO
        send(8'h44, 0, 1, 0); send(8'h45, 0, 0, 0);
        check(st_dr && st_fifo_err, "R11 data before clear", int'({st_dr, st_fifo_err}), 3);
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0; @(negedge clk);
        check(!st_dr && !st_fifo_err && !rx_ready && !st_oe, "R11 cleared",
              int'({st_dr, st_fifo_err, rx_ready, st_oe}), 0);

        // R12 pop while empty does nothing
        pop_man = 1'b1; @(negedge clk); pop_man = 1'b0; @(negedge clk);
        check(!st_dr && !st_oe, "R12 empty pop", int'({st_dr, st_oe}), 0);
        send(8'h6B, 0, 0, 1);
        check(st_dr, "R12 next frame stored", int'(st_dr), 1);
        drain(1);
        check(!st_dr && expq.size() == 0, "R7 all entries accounted", expq.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule